// File: doc/BRIEF.md
# Latch-or-Register Transceiver Path Stage

This block is one direction of a 16-bit bus transceiver data path with two parity bits, 18 bits in all. One storage element serves three data-flow modes. While the latch-enable input is high, the stage is transparent. While latch-enable is low, a rising transition on the capture-clock pin loads the word. At all other times the stage holds its stored word. An active-low output enable controls a per-bit drive-enable vector, which models a three-state output. A full transceiver uses two instances, one per direction, and their controls are fully independent.

The whole stage runs on one system clock, `clk`. The capture-clock pin is sampled on every `clk` edge, and its rising transition is detected by comparing the current sample with the previous one. A small state machine sets the storage mode on every system cycle. It has four named states:

- `MODE_IDLE`: reset.
- `MODE_FOLLOW`: latch-enable high, storage tracks the input.
- `MODE_GRAB`: latch-enable low and a capture-clock rise is seen, storage loads the input.
- `MODE_KEEP`: latch-enable low and no rise, storage holds.

The transitions depend only on reset, latch-enable and the detected rise. Any state goes to `MODE_IDLE` under reset. Otherwise latch-enable high selects `MODE_FOLLOW`. Latch-enable low with a rise selects `MODE_GRAB`. Latch-enable low without a rise selects `MODE_KEEP`.

Top module: `tcv_path_stage`

## Requirements
- R1: While `rst` is high, `drv_en` is all zeros and `dout` is zero. The stored word is cleared to zero, so with latch-enable low after reset the output reads zero until a capture.
- R2: While `oe_n` is high and `rst` is low, `drv_en` is all zeros and `dout` reads zero, whatever `le`, `cap_clk` and `din` are.
- R3: While `oe_n` is low and `rst` is low, every bit of `drv_en` is 1.
- R4: While `le` is high and the output is enabled, `dout` equals `din` in the same cycle, and the stored word takes `din` at each `clk` edge.
- R5: While `le` is low, a `clk` edge where `cap_clk` is sampled high after being sampled low on the previous edge loads `din` into storage. The stored word appears on `dout` from the next cycle.
- R6: While `le` is low and no such rise is seen, the stored word does not change, whether `cap_clk` stays high or stays low.
- R7: After `le` falls, `dout` holds the `din` of the last cycle with `le` high. If a capture-clock rise is sampled on the same edge where `le` is first seen low, the word present at that edge is stored instead.
- R8: Storage keeps working while the output is disabled. A word captured with `oe_n` high appears once `oe_n` goes low.
- R9: The previous-sample register of `cap_clk` resets to high. A `cap_clk` that is already high when reset is released causes no capture until it has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every state element updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| le | input | 1 | Latch enable: high for transparent, low for clocked/hold |
| cap_clk | input | 1 | Capture-clock pin, sampled by `clk` |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Input word: bits 15:0 data, bits 17:16 parity |
| dout | output | 18 | Output word, zero while not driven |
| drv_en | output | 18 | Per-bit drive enable modelling the three-state output |

## Verification
Two pairs of events can fall on the same `clk` edge:

- Latch-enable falling together with a capture-clock rise. The bench times the fall of `le` and the rise of `cap_clk` onto the same negative-edge drive slot. It then expects the word present at that edge, not the previous one.
- The output enable toggling while a capture is happening. The bench captures with `oe_n` high, then lowers `oe_n`, and expects the newly captured word.

A behavioural reference model in the bench tracks the previous capture-clock sample and the stored word. It judges both overlaps the same way it judges every other cycle, by comparing `dout` and `drv_en` against the model.

// File: rtl/tcv_stage_pkg.sv
package tcv_stage_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_FOLLOW = 2'd1,
        MODE_KEEP   = 2'd2,
        MODE_GRAB   = 2'd3
    } mode_e;
endpackage

// File: rtl/tcv_edge_detect.sv
module tcv_edge_detect #(
    parameter bit IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LEVEL;
        else     prev_q <= pin;
    end

    assign rise = pin & ~prev_q;

    // R9: a rise is only reported after a low sample taken out of reset
    assert_rise_real_R9: assert property (@(posedge clk) disable iff (rst)
        rise |-> (pin && !$past(pin)));
endmodule

// File: rtl/tcv_store.sv
module tcv_store
    import tcv_stage_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic         rise,
    input  logic [W-1:0] din,
    output logic [W-1:0] stored,
    output mode_e        mode_q
);
    mode_e mode_d;

    always_comb begin
        unique case ({rst, le, rise})
            3'b100, 3'b101, 3'b110, 3'b111: mode_d = MODE_IDLE;
            3'b010, 3'b011:                 mode_d = MODE_FOLLOW;
            3'b001:                         mode_d = MODE_GRAB;
            default:                        mode_d = MODE_KEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        unique case (mode_d)
            MODE_IDLE:   stored <= '0;
            MODE_FOLLOW: stored <= din;
            MODE_GRAB:   stored <= din;
            MODE_KEEP:   stored <= stored;
        endcase
    end

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (stored == '0));
    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        le |=> (stored == $past(din)));
    assert_grab_R5: assert property (@(posedge clk) disable iff (rst)
        (!le && rise) |=> (stored == $past(din)));
    assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (!le && !rise) |=> $stable(stored));
endmodule

// File: rtl/tcv_drive.sv
module tcv_drive #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         le,
    input  logic [W-1:0] din,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic [W-1:0] drv_en
);
    logic          active;
    logic [W-1:0]  word;

    assign active = ~oe_n & ~rst;
    assign word   = le ? din : stored;

    for (genvar b = 0; b < W; b++) begin : g_lane
        assign drv_en[b] = active;
        assign dout[b]   = active & word[b];
    end

    assert_off_R2: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (drv_en == '0 && dout == '0));
    assert_on_R3: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (&drv_en));
    assert_thru_R4: assert property (@(posedge clk) disable iff (rst)
        (le && !oe_n) |-> (dout == din));
endmodule

// File: rtl/tcv_path_stage.sv
module tcv_path_stage
    import tcv_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      le,
    input  logic                      cap_clk,
    input  logic                      oe_n,
    input  logic [DATA_W+PAR_W-1:0]   din,
    output logic [DATA_W+PAR_W-1:0]   dout,
    output logic [DATA_W+PAR_W-1:0]   drv_en
);
    localparam int W = DATA_W + PAR_W;

    logic         rise;
    logic [W-1:0] stored;
    mode_e        mode_q;

    tcv_edge_detect #(.IDLE_LEVEL(1'b1)) u_edge (
        .clk (clk),
        .rst (rst),
        .pin (cap_clk),
        .rise(rise)
    );

    tcv_store #(.W(W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .le    (le),
        .rise  (rise),
        .din   (din),
        .stored(stored),
        .mode_q(mode_q)
    );

    tcv_drive #(.W(W)) u_drive (
        .clk   (clk),
        .rst   (rst),
        .oe_n  (oe_n),
        .le    (le),
        .din   (din),
        .stored(stored),
        .dout  (dout),
        .drv_en(drv_en)
    );

    // R1: the first cycle after reset reads back a cleared store
    assert_idle_R1: assert property (@(posedge clk)
        (mode_q == MODE_IDLE && !rst && !le && !oe_n) |-> (dout == '0));
endmodule

// File: tb/test_tcv_path_stage.sv
module test_tcv_path_stage;
    localparam int  PERIOD = 10;
    localparam int  W      = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         le = 1'b0;
    logic         cap_clk = 1'b1;
    logic         oe_n = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic [W-1:0] drv_en;

    int total = 0;
    int bad   = 0;
    string focus = "";

    logic [W-1:0] m_store = '0;
    bit           m_prev  = 1'b1;
    bit           m_le_was = 1'b0;

    tcv_path_stage i_tcv_path_stage (
        .clk(clk), .rst(rst), .le(le), .cap_clk(cap_clk), .oe_n(oe_n),
        .din(din), .dout(dout), .drv_en(drv_en)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s%s act=%h exp=%h t=%0t", tag, focus, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit l, input bit c, input bit o, input logic [W-1:0] d);
        logic [W-1:0] e_out;
        logic [W-1:0] e_en;
        string        tag;
        bit           rise;
        @(negedge clk);
        rst = r; le = l; cap_clk = c; oe_n = o; din = d;
        #1;
        rise = c & ~m_prev;
        if (r)        tag = "R1";
        else if (o)   tag = "R2";
        else if (l)   tag = "R4";
        else if (m_le_was) tag = "R7";
        else          tag = "R6";
        e_en  = (!r && !o) ? '1 : '0;
        e_out = (!r && !o) ? (l ? d : m_store) : '0;
        check(tag, dout, e_out);
        check((!r && !o) ? "R3" : tag, drv_en, e_en);
        @(posedge clk);
        if (r) begin
            m_store = '0; m_prev = 1'b1; m_le_was = 1'b0;
        end else begin
            if (l || rise) m_store = d;
            m_prev   = c;
            m_le_was = l;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        focus = " reset";
        for (int i = 0; i < 3; i++) step(1, i[0], 1, 0, 18'h3A5A5);
        // R9: clock pin high at release, then held high: no capture
        focus = " R9";
        step(0, 0, 1, 0, 18'h11111);
        step(0, 0, 1, 0, 18'h22222);
        step(0, 0, 0, 0, 18'h33333);
        step(0, 0, 1, 0, 18'h04444); // R5 capture
        step(0, 0, 1, 0, 18'h05555);
        step(0, 0, 0, 0, 18'h06666); // R6 held low
        focus = " R4";
        step(0, 1, 0, 0, 18'h2BEEF);
        step(0, 1, 1, 0, 18'h1CAFE);
        step(0, 1, 0, 0, 18'h3F00D);
        focus = " R7 plain fall";
        step(0, 0, 0, 0, 18'h00001);
        step(0, 0, 0, 0, 18'h00002);
        step(0, 1, 0, 0, 18'h12345);
        focus = " R7 fall with rise";
        step(0, 0, 1, 0, 18'h2ABCD);
        step(0, 0, 1, 0, 18'h00003);
        step(0, 0, 0, 0, 18'h00004);
        focus = " R8";
        step(0, 0, 1, 1, 18'h3C3C3);
        step(0, 0, 1, 1, 18'h00005);
        step(0, 0, 1, 0, 18'h00006);
        step(0, 0, 0, 0, 18'h00007);
        focus = " R2";
        step(0, 1, 1, 1, 18'h3FFFF);
        step(0, 0, 0, 1, 18'h3FFFF);
        focus = " random";
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 50) == 0, $urandom % 3 == 0, $urandom % 2,
                 $urandom % 5 == 0, W'($urandom));
        end
        focus = " R1 after";
        step(1, 0, 0, 0, 18'h3FFFF);
        step(0, 0, 0, 0, 18'h3FFFF);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule